// File: doc/BRIEF.md
# Photon Event Validator and Centroider

This block sits behind the window-forming stage of a photon-counting imager. Each clock it receives a group of eight 3x3 pixel neighbourhoods, and for each one it also receives the row and column of the centre pixel. Each lane decides on its own whether its centre pixel is a photon event. An event must be brighter than a programmable discrimination level and must be the local maximum of its neighbourhood.

For every accepted event the block finds where the event lies within the pixel, in both X and Y. It uses a truncated three-point centre of gravity and gives the result in steps of one thirty-second of a pixel. The lanes are independent and fully pipelined, so each lane accepts a new window on every clock. Each lane reports a valid flag, the integer coordinates and two signed 5-bit fractional offsets, and all of these leave the block in the same cycle.

The discrimination level is taken from an input at start of frame and held for the rest of the frame. A window presented together with the start-of-frame strobe is already judged against the new level.

Top module: `photon_centroid_array`

## Requirements
- R1: A lane flags an event only when its centre pixel is strictly greater than the effective discrimination level. A centre pixel equal to the level is rejected.
- R2: Number the neighbourhood in raster order, top row first and left to right, with the centre at index 4. The centre must be greater than or equal to indices 0 to 3 and strictly greater than indices 5 to 8, so a two-pixel plateau produces exactly one event.
- R3: The X offset equals floor(32*(right-left)/(left+centre+right)), where left is index 3 and right is index 5. It is given as a 5-bit two's complement value.
- R4: The Y offset equals floor(32*(below-above)/(above+centre+below)), where above is index 1 and below is index 7. It is given as a 5-bit two's complement value.
- R5: For accepted events both offsets reach the full range from -16 to +15 without wrapping. For example, left equal to the centre with right at zero gives -16.
- R6: When a lane reports no event, its row, column and both offsets are all zero.
- R7: The results for a window appear 7 clocks after the edge that captures it. The valid flag, row, column and offsets all appear in that same cycle, and a new window can be accepted on every clock.
- R8: The discrimination level is loaded from `thresh_in` only while `sof` is high, and that window already uses the new level. At all other times, changes on `thresh_in` have no effect.
- R9: The eight lanes are evaluated independently of each other in every cycle. Lane i uses bits [(9*i+k)*8 +: 8] of `win_pix` for pixel k.
- R10: While `rst` is high, and after it is released until new windows flow through, all outputs are zero and the discrimination level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start of frame; loads the discrimination level |
| thresh_in | input | 8 | Discrimination level candidate |
| win_valid | input | 1 | The eight windows on this clock are real data |
| win_pix | input | 576 | Eight windows of nine 8-bit pixels, raster order |
| win_row | input | 80 | Centre row per lane, 10 bits each |
| win_col | input | 80 | Centre column per lane, 10 bits each |
| evt_valid | output | 8 | Event flag per lane |
| evt_row | output | 80 | Event row per lane |
| evt_col | output | 80 | Event column per lane |
| evt_dx | output | 40 | Signed X offset per lane, 1/32 pixel units |
| evt_dy | output | 40 | Signed Y offset per lane, 1/32 pixel units |

## Verification
Every result is due exactly seven clocks after the window that produced it is captured. This holds for the flag, the coordinates and both offsets, and it is the same whether the window is accepted or rejected. The bench models each window with plain integer arithmetic and floor division as soon as it drives the window, and puts the expected outputs into a queue that is seven entries deep. On each falling edge the bench takes the oldest entry from the queue and compares it field by field and lane by lane. Any stray or missing cycle of delay, or any field that is out of step with the others, therefore shows up as a mismatch. The discrimination level is modelled with the same start-of-frame rule, so a level that is loaded too early or too late is caught on the first window it affects.

// File: rtl/pcent_pkg.sv
package pcent_pkg;
  // raster indices inside a 3x3 neighbourhood
  localparam int NB_PIX  = 9;
  localparam int IDX_UP  = 1;
  localparam int IDX_LF  = 3;
  localparam int IDX_CTR = 4;
  localparam int IDX_RT  = 5;
  localparam int IDX_DN  = 7;
endpackage

// File: rtl/pcent_frac_div.sv
// Pipelined floor division: quo = floor(+-mag / den), one quotient bit per stage,
// followed by a sign/floor fix-up register. Latency FB+1 clocks. den==0 gives 0.
module pcent_frac_div #(
  parameter int NW = 13,
  parameter int DW = 10,
  parameter int FB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] mag,
  input  logic          neg,
  input  logic [DW-1:0] den,
  output logic [FB-1:0] quo
);
  localparam int WW = (NW > DW + FB) ? NW : DW + FB;

  logic [WW-1:0] rin [0:FB-1];
  logic [WW-1:0] trial [0:FB-1];
  logic [WW-1:0] rnx [0:FB-1];
  logic [DW-1:0] din [0:FB-1];
  logic [FB-1:0] qin [0:FB-1];
  logic [FB-1:0] qnx [0:FB-1];
  logic          nin [0:FB-1];

  logic [WW-1:0] rem_q [0:FB-1];
  logic [DW-1:0] den_q [0:FB-1];
  logic [FB-1:0] quo_q [0:FB-1];
  logic          neg_q [0:FB-1];

  always_comb begin
    rin[0] = WW'(mag);
    din[0] = den;
    qin[0] = '0;
    nin[0] = neg;
    for (int s = 1; s < FB; s++) begin
      rin[s] = rem_q[s-1];
      din[s] = den_q[s-1];
      qin[s] = quo_q[s-1];
      nin[s] = neg_q[s-1];
    end
    for (int s = 0; s < FB; s++) begin
      trial[s] = WW'(din[s]) << (FB - 1 - s);
      qnx[s]   = qin[s];
      rnx[s]   = rin[s];
      if (rin[s] >= trial[s]) begin
        rnx[s]            = rin[s] - trial[s];
        qnx[s][FB-1-s]    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < FB; s++) begin
      if (rst) begin
        rem_q[s] <= '0;
        den_q[s] <= '0;
        quo_q[s] <= '0;
        neg_q[s] <= 1'b0;
      end else begin
        rem_q[s] <= rnx[s];
        den_q[s] <= din[s];
        quo_q[s] <= qnx[s];
        neg_q[s] <= nin[s];
      end
    end
  end

  // floor correction for negative quotients
  logic signed [FB:0] pos_v, neg_v, res_v;
  logic               rnz;
  always_comb begin
    rnz   = (rem_q[FB-1] != '0);
    pos_v = signed'({1'b0, quo_q[FB-1]});
    neg_v = -(pos_v + signed'({{FB{1'b0}}, rnz}));
    res_v = neg_q[FB-1] ? neg_v : pos_v;
  end

  always_ff @(posedge clk) begin
    if (rst)                      quo <= '0;
    else if (den_q[FB-1] == '0)   quo <= '0;
    else                          quo <= res_v[FB-1:0];
  end

  // R3: the long division must leave a remainder below the divisor
  a_r3_rem_below_div: assert property (@(posedge clk) disable iff (rst)
    (den_q[FB-1] != '0) |-> (rem_q[FB-1] < WW'(den_q[FB-1])));

  // R5: the signed result must fit the output field without wrapping
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (den_q[FB-1] != '0) |-> (res_v[FB] == res_v[FB-1]));
endmodule

// File: rtl/pcent_lane.sv
module pcent_lane
  import pcent_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int FB    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [NB_PIX*PIX_W-1:0] pix,
  input  logic [ROW_W-1:0]        row,
  input  logic [COL_W-1:0]        col,
  input  logic [PIX_W-1:0]        thr,
  output logic                    o_vld,
  output logic [ROW_W-1:0]        o_row,
  output logic [COL_W-1:0]        o_col,
  output logic [FB-1:0]           o_dx,
  output logic [FB-1:0]           o_dy
);
  localparam int NW  = PIX_W + FB;
  localparam int DW  = PIX_W + 2;
  localparam int DLY = FB + 1;

  logic [PIX_W-1:0] p [0:NB_PIX-1];
  for (genvar k = 0; k < NB_PIX; k++) begin : g_unpack
    assign p[k] = pix[k*PIX_W +: PIX_W];
  end

  logic             peak, hit, nx, ny;
  logic [PIX_W-1:0] difx, dify;
  logic [DW-1:0]    denx, deny;

  always_comb begin
    peak = 1'b1;
    for (int k = 0; k < NB_PIX; k++) begin
      if (k < IDX_CTR)      peak = peak & (p[IDX_CTR] >= p[k]);
      else if (k > IDX_CTR) peak = peak & (p[IDX_CTR] >  p[k]);
    end
    hit  = in_vld & peak & (p[IDX_CTR] > thr);
    nx   = p[IDX_LF] > p[IDX_RT];
    ny   = p[IDX_UP] > p[IDX_DN];
    difx = nx ? p[IDX_LF] - p[IDX_RT] : p[IDX_RT] - p[IDX_LF];
    dify = ny ? p[IDX_UP] - p[IDX_DN] : p[IDX_DN] - p[IDX_UP];
    denx = DW'(p[IDX_LF]) + DW'(p[IDX_CTR]) + DW'(p[IDX_RT]);
    deny = DW'(p[IDX_UP]) + DW'(p[IDX_CTR]) + DW'(p[IDX_DN]);
  end

  // stage 1: qualification and operand capture; rejected windows carry zeros
  logic             s1_vld, s1_nx, s1_ny;
  logic [ROW_W-1:0] s1_row;
  logic [COL_W-1:0] s1_col;
  logic [NW-1:0]    s1_mx, s1_my;
  logic [DW-1:0]    s1_dx, s1_dy;

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      s1_vld <= 1'b0;
      s1_row <= '0;
      s1_col <= '0;
      s1_mx  <= '0;
      s1_my  <= '0;
      s1_nx  <= 1'b0;
      s1_ny  <= 1'b0;
      s1_dx  <= '0;
      s1_dy  <= '0;
    end else begin
      s1_vld <= 1'b1;
      s1_row <= row;
      s1_col <= col;
      s1_mx  <= {difx, {FB{1'b0}}};
      s1_my  <= {dify, {FB{1'b0}}};
      s1_nx  <= nx;
      s1_ny  <= ny;
      s1_dx  <= denx;
      s1_dy  <= deny;
    end
  end

  pcent_frac_div #(.NW(NW), .DW(DW), .FB(FB)) u_divx (
    .clk(clk), .rst(rst), .mag(s1_mx), .neg(s1_nx), .den(s1_dx), .quo(o_dx));
  pcent_frac_div #(.NW(NW), .DW(DW), .FB(FB)) u_divy (
    .clk(clk), .rst(rst), .mag(s1_my), .neg(s1_ny), .den(s1_dy), .quo(o_dy));

  // coordinates follow the divider depth
  logic             d_vld [0:DLY-1];
  logic [ROW_W-1:0] d_row [0:DLY-1];
  logic [COL_W-1:0] d_col [0:DLY-1];

  always_ff @(posedge clk) begin
    for (int k = 0; k < DLY; k++) begin
      if (rst) begin
        d_vld[k] <= 1'b0;
        d_row[k] <= '0;
        d_col[k] <= '0;
      end else if (k == 0) begin
        d_vld[k] <= s1_vld;
        d_row[k] <= s1_row;
        d_col[k] <= s1_col;
      end else begin
        d_vld[k] <= d_vld[k-1];
        d_row[k] <= d_row[k-1];
        d_col[k] <= d_col[k-1];
      end
    end
  end

  assign o_vld = d_vld[DLY-1];
  assign o_row = d_row[DLY-1];
  assign o_col = d_col[DLY-1];

  // R1: a qualified window had a centre above the level it was judged against
  a_r1_peak_above_level: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> ($past(p[IDX_CTR]) > $past(thr)));

  // R6: a quiet lane drives zeros on every field
  a_r6_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    !o_vld |-> (o_row == '0 && o_col == '0 && o_dx == '0 && o_dy == '0));
endmodule

// File: rtl/photon_centroid_array.sv
module photon_centroid_array
  import pcent_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PIX_W = 8,
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int FB    = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sof,
  input  logic [PIX_W-1:0]              thresh_in,
  input  logic                          win_valid,
  input  logic [LANES*NB_PIX*PIX_W-1:0] win_pix,
  input  logic [LANES*ROW_W-1:0]        win_row,
  input  logic [LANES*COL_W-1:0]        win_col,
  output logic [LANES-1:0]              evt_valid,
  output logic [LANES*ROW_W-1:0]        evt_row,
  output logic [LANES*COL_W-1:0]        evt_col,
  output logic [LANES*FB-1:0]           evt_dx,
  output logic [LANES*FB-1:0]           evt_dy
);
  localparam int WIN_W = NB_PIX * PIX_W;

  logic [PIX_W-1:0] thr_q, thr_eff;

  assign thr_eff = sof ? thresh_in : thr_q;

  always_ff @(posedge clk) begin
    if (rst) thr_q <= '0;
    else     thr_q <= thr_eff;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pcent_lane #(.PIX_W(PIX_W), .ROW_W(ROW_W), .COL_W(COL_W), .FB(FB)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .in_vld(win_valid),
      .pix   (win_pix[i*WIN_W +: WIN_W]),
      .row   (win_row[i*ROW_W +: ROW_W]),
      .col   (win_col[i*COL_W +: COL_W]),
      .thr   (thr_eff),
      .o_vld (evt_valid[i]),
      .o_row (evt_row[i*ROW_W +: ROW_W]),
      .o_col (evt_col[i*COL_W +: COL_W]),
      .o_dx  (evt_dx[i*FB +: FB]),
      .o_dy  (evt_dy[i*FB +: FB])
    );
  end

  // R8: the level only moves on a start-of-frame strobe
  a_r8_level_hold: assert property (@(posedge clk) disable iff (rst)
    !sof |=> $stable(thr_q));
endmodule

// File: tb/sim_photon_centroid_array.sv
module sim_photon_centroid_array;
  localparam int LANES = 8;
  localparam int PW    = 8;
  localparam int RW    = 10;
  localparam int CW    = 10;
  localparam int FB    = 5;
  localparam int LAT   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 1'b0;
  logic [PW-1:0] thresh_in = '0;
  logic win_valid = 1'b0;
  logic [LANES*9*PW-1:0] win_pix = '0;
  logic [LANES*RW-1:0] win_row = '0;
  logic [LANES*CW-1:0] win_col = '0;
  logic [LANES-1:0] evt_valid;
  logic [LANES*RW-1:0] evt_row;
  logic [LANES*CW-1:0] evt_col;
  logic [LANES*FB-1:0] evt_dx, evt_dy;

  always #2 clk = ~clk;

  photon_centroid_array u0 (
    .clk(clk), .rst(rst), .sof(sof), .thresh_in(thresh_in),
    .win_valid(win_valid), .win_pix(win_pix), .win_row(win_row), .win_col(win_col),
    .evt_valid(evt_valid), .evt_row(evt_row), .evt_col(evt_col),
    .evt_dx(evt_dx), .evt_dy(evt_dy));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int pix [LANES][9];
  int rws [LANES];
  int cls [LANES];
  int thr_m = 0;

  logic [LANES-1:0]    qv [$];
  logic [LANES*RW-1:0] qr [$];
  logic [LANES*CW-1:0] qc [$];
  logic [LANES*FB-1:0] qx [$];
  logic [LANES*FB-1:0] qy [$];

  task automatic chk(input string tag, input int lane, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s lane %0d actual=%0d expected=%0d at %0t", tag, lane, act, exp, $time);
    end
  endtask

  function automatic int fdiv(input int n, input int d);
    int q;
    if (d == 0) return 0;
    q = n / d;
    if ((n % d) != 0 && n < 0) q--;
    return q;
  endfunction

  task automatic compare_out();
    logic [LANES-1:0] ev;
    logic [LANES*RW-1:0] er;
    logic [LANES*CW-1:0] ec;
    logic [LANES*FB-1:0] ex, ey;
    ev = qv.pop_front(); er = qr.pop_front(); ec = qc.pop_front();
    ex = qx.pop_front(); ey = qy.pop_front();
    for (int l = 0; l < LANES; l++) begin
      chk("R1/R2 event flag", l, int'(evt_valid[l]), int'(ev[l]));
      chk("R7/R6 row", l, int'(evt_row[l*RW +: RW]), int'(er[l*RW +: RW]));
      chk("R7/R6 col", l, int'(evt_col[l*CW +: CW]), int'(ec[l*CW +: CW]));
      chk("R3/R5 x offset", l, int'(evt_dx[l*FB +: FB]), int'(ex[l*FB +: FB]));
      chk("R4/R5 y offset", l, int'(evt_dy[l*FB +: FB]), int'(ey[l*FB +: FB]));
    end
  endtask

  // one clock: check the oldest expectation, drive new windows, model them
  task automatic tick(input bit v, input bit s, input int th);
    logic [LANES-1:0] ev;
    logic [LANES*RW-1:0] er;
    logic [LANES*CW-1:0] ec;
    logic [LANES*FB-1:0] ex, ey;
    int te, dx, dy;
    bit pk, ok;
    @(negedge clk);
    if (qv.size() == LAT) compare_out();
    rst = 1'b0;
    // R8: level loaded only with sof, used by that same window
    te = s ? th : thr_m;
    thr_m = te;
    sof = s; thresh_in = PW'(th); win_valid = v;
    ev = '0; er = '0; ec = '0; ex = '0; ey = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < 9; k++) win_pix[(l*9+k)*PW +: PW] = PW'(pix[l][k]);
      win_row[l*RW +: RW] = RW'(rws[l]);
      win_col[l*CW +: CW] = CW'(cls[l]);
      pk = 1'b1;
      for (int k = 0; k < 9; k++) begin
        if (k < 4 && pix[l][4] < pix[l][k]) pk = 1'b0;   // R2 ties allowed before
        if (k > 4 && pix[l][4] <= pix[l][k]) pk = 1'b0;  // R2 ties rejected after
      end
      ok = v && pk && (pix[l][4] > te);                  // R1 strict level
      if (ok) begin
        dx = fdiv(32 * (pix[l][5] - pix[l][3]), pix[l][3] + pix[l][4] + pix[l][5]);
        dy = fdiv(32 * (pix[l][7] - pix[l][1]), pix[l][1] + pix[l][4] + pix[l][7]);
        ev[l] = 1'b1;
        er[l*RW +: RW] = RW'(rws[l]);
        ec[l*CW +: CW] = CW'(cls[l]);
        ex[l*FB +: FB] = FB'(dx);
        ey[l*FB +: FB] = FB'(dy);
      end
    end
    qv.push_back(ev); qr.push_back(er); qc.push_back(ec);
    qx.push_back(ex); qy.push_back(ey);
  endtask

  task automatic set_win(input int l, input int up, input int lf, input int c,
                         input int rt, input int dn, input int other);
    for (int k = 0; k < 9; k++) pix[l][k] = other;
    pix[l][1] = up; pix[l][3] = lf; pix[l][4] = c; pix[l][5] = rt; pix[l][7] = dn;
    rws[l] = 100 + l; cls[l] = 8 * l + 3;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) set_win(l, 0, 0, 0, 0, 0, 0);
    // R10: outputs quiet while reset is held
    repeat (4) begin
      @(negedge clk);
      chk("R10 reset valid", 0, int'(evt_valid), 0);
      chk("R10 reset dx", 0, int'(evt_dx != '0), 0);
    end
    for (int k = 0; k < LAT; k++) begin
      qv.push_back('0); qr.push_back('0); qc.push_back('0);
      qx.push_back('0); qy.push_back('0);
    end

    // directed set, level 50 loaded with sof
    set_win(0, 0, 100, 100, 0, 0, 0);     // R2 tie on left accepted, R5 dx=-16
    set_win(1, 0, 0, 100, 100, 0, 0);     // R2 tie on right rejected
    set_win(2, 100, 0, 100, 0, 0, 0);     // R2 tie above accepted, dy=-16
    set_win(3, 0, 0, 100, 0, 100, 0);     // R2 tie below rejected
    set_win(4, 0, 0, 50, 0, 0, 0);        // R1 equal to level rejected
    set_win(5, 0, 0, 51, 0, 0, 0);        // R1 one above level accepted
    set_win(6, 0, 0, 255, 254, 0, 0);     // R5 dx=+15
    set_win(7, 13, 10, 20, 13, 10, 5);    // R3 dx=2, R4 dy=-3 (floor)
    tick(1'b1, 1'b1, 50);
    // R8: thresh_in changes without sof, still level 50
    tick(1'b1, 1'b0, 200);
    // R8: sof loads 200, centre 100 now rejected
    tick(1'b1, 1'b1, 200);
    tick(1'b0, 1'b0, 0);                  // R6 idle window gives zeros
    tick(1'b1, 1'b1, 0);
    for (int k = 0; k < LAT + 2; k++) tick(1'b0, 1'b0, 7);

    // R9 random windows, independent per lane, back to back
    for (int n = 0; n < 3000; n++) begin
      for (int l = 0; l < LANES; l++) begin
        int c;
        c = int'($urandom_range(0, 255));
        for (int k = 0; k < 9; k++) begin
          int m;
          m = int'($urandom_range(0, 7));
          if (m == 0)      pix[l][k] = c;
          else if (m == 1) pix[l][k] = int'($urandom_range(0, 255));
          else             pix[l][k] = int'($urandom_range(0, c));
        end
        pix[l][4] = c;
        rws[l] = int'($urandom_range(0, 1023));
        cls[l] = int'($urandom_range(0, 1023));
      end
      tick(($urandom_range(0, 9) != 0), ($urandom_range(0, 49) == 0),
           int'($urandom_range(0, 200)));
    end
    for (int k = 0; k < LAT + 1; k++) tick(1'b0, 1'b0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule